// File: doc/BRIEF.md
# Edge Timestamp Capture Channel

This block is one channel of a timer. It stamps edges of an external input with the value of a shared 24-bit time base. In pulse-width mode it keeps the time of a pulse's leading edge and the time of its trailing edge. In period mode it keeps the times of the two most recent edges of one chosen polarity. Software reads the two capture registers through a small read port and takes their difference itself. A sticky completion flag shows that a new measurement is ready, and software clears it by writing a one.

The input pin is resynchronised before edges are detected, so every stamp lags the pin by a fixed number of clocks. A bus read of the A register always wins over the hardware. If a capture into A falls in the same cycle as such a read, the capture is held back until the first cycle that does not read A. The B register is not held back. This gives a short window, defined in advance, in which the two registers do not belong to the same measurement. Software avoids it by reading the pair twice.

Top module: `icap_channel`

## Requirements
- R1: After reset, both capture registers read zero and the completion flag is low.
- R2: A level change on `pin_in` is stamped with the `tbase` value present at the third rising clock edge after the change, and the stamp can be read just after that edge.
- R3: With `cfg_period`=0, the leading edge of a pulse loads B and the trailing edge loads A. With `cfg_pol`=1 the pulse is positive (leading edge rising, trailing edge falling). With `cfg_pol`=0 it is negative.
- R4: In pulse-width mode, a trailing edge is ignored unless a leading edge has come before it since reset or since the last configuration change. A is left unchanged and the flag is not raised.
- R5: With `cfg_period`=1, each edge of the chosen polarity (`cfg_pol`=1 rising, 0 falling) loads A, and the former A value moves into B. Edges of the other polarity change nothing.
- R6: In period mode, the first capture after reset or after a configuration change loads A but does not raise the flag.
- R7: The flag rises when a completed measurement is written into A. It stays high until software clears it.
- R8: A cycle with `flag_wr`=1 and `flag_wdata`=1 clears the flag. `flag_wdata`=0 leaves it unchanged. If a measurement completes in the same cycle as a clear, the flag stays high.
- R9: `rd_data` shows A when `rd_sel`=0 and B when `rd_sel`=1, in the same cycle.
- R10: A cycle with `rd_en`=1 and `rd_sel`=0 reads the old A, even if a capture into A happens in that cycle. That capture is stored on the first following cycle without such a read. The value stored is the time base at the edge, and the flag rises then.
- R11: Captures whose edges straddle time-base rollover store raw values, so (A - B) mod 2^24 gives the true interval.
- R12: In period mode, when the capture into A is held back, B still takes the former A at the edge. Until the capture is stored, B equals A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbase | input | 24 | Shared time base |
| pin_in | input | 1 | Asynchronous input signal |
| cfg_period | input | 1 | 0 pulse-width mode, 1 period mode |
| cfg_pol | input | 1 | Edge polarity select |
| rd_en | input | 1 | Bus read strobe |
| rd_sel | input | 1 | 0 selects A, 1 selects B |
| rd_data | output | 24 | Selected capture register |
| flag_wr | input | 1 | Write strobe to the flag bit |
| flag_wdata | input | 1 | Write data; 1 clears the flag |
| flag | output | 1 | Sticky completion flag |

## Verification
An edge shows in the registers just after the third rising clock edge that follows the pin change. The bench therefore drives the pin on a falling edge. It samples the time base just before the third rising edge and compares the registers on the next falling edge. `rd_data` is combinational, so it is checked in the same half-cycle as `rd_sel`. The flag appears in the same cycle as the register it belongs to. A held-back capture appears one clock after the last cycle that reads A. The bench checks the old value during the hold and the stamped value one cycle after the read is released.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic {
    MODE_WIDTH  = 1'b0,
    MODE_PERIOD = 1'b1
  } icap_mode_e;

  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } icap_sel_e;

  // edge of the requested polarity: pol=1 selects rising
  function automatic logic pick_edge(input logic pol, input logic rise, input logic fall);
    return pol ? rise : fall;
  endfunction

  // edge opposite to the requested polarity
  function automatic logic other_edge(input logic pol, input logic rise, input logic fall);
    return pol ? fall : rise;
  endfunction

endpackage

// File: rtl/icap_edge_sync.sv
module icap_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic rise_evt,
  output logic fall_evt
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   last_lvl;
  logic                   cur_lvl;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign cur_lvl = chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_lvl <= 1'b0;
    else        last_lvl <= cur_lvl;
  end

  assign rise_evt = cur_lvl & ~last_lvl;
  assign fall_evt = ~cur_lvl & last_lvl;

endmodule

// File: rtl/icap_capture.sv
module icap_capture
  import icap_pkg::*;
#(
  parameter int unsigned TB_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] tbase,
  input  logic            cfg_period,
  input  logic            cfg_pol,
  input  logic            rise_evt,
  input  logic            fall_evt,
  input  logic            a_blocked,
  output logic [TB_W-1:0] cap_a,
  output logic [TB_W-1:0] cap_b,
  output logic            pend,
  output logic            lead_evt,
  output logic            a_evt,
  output logic            a_commit,
  output logic            meas_commit
);

  icap_mode_e      mode, mode_q;
  logic            pol_q;
  logic            cfg_chg;
  logic            armed;
  logic            trail_evt;
  logic            per_evt;
  logic            a_meas;
  logic            want_a;
  logic [TB_W-1:0] held;
  logic            held_meas;
  logic [TB_W-1:0] a_value;
  logic            a_value_meas;

  assign mode    = icap_mode_e'(cfg_period);
  assign cfg_chg = (mode != mode_q) || (cfg_pol != pol_q);

  assign lead_evt  = !cfg_chg && (mode == MODE_WIDTH)  && pick_edge(cfg_pol, rise_evt, fall_evt);
  assign trail_evt = !cfg_chg && (mode == MODE_WIDTH)  && other_edge(cfg_pol, rise_evt, fall_evt);
  assign per_evt   = !cfg_chg && (mode == MODE_PERIOD) && pick_edge(cfg_pol, rise_evt, fall_evt);

  assign a_evt  = (trail_evt && armed) || per_evt;
  assign a_meas = trail_evt || (per_evt && armed);
  assign want_a = a_evt || pend;

  assign a_value      = a_evt ? tbase  : held;
  assign a_value_meas = a_evt ? a_meas : held_meas;

  assign a_commit    = want_a && !a_blocked;
  assign meas_commit = a_commit && a_value_meas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_WIDTH;
      pol_q  <= 1'b0;
    end else begin
      mode_q <= mode;
      pol_q  <= cfg_pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (cfg_chg)   armed <= 1'b0;
    else if (lead_evt)  armed <= 1'b1;
    else if (trail_evt) armed <= 1'b0;
    else if (per_evt)   armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a     <= '0;
      pend      <= 1'b0;
      held      <= '0;
      held_meas <= 1'b0;
    end else begin
      pend <= want_a && a_blocked;
      if (a_commit) cap_a <= a_value;
      if (want_a && a_blocked) begin
        held      <= a_value;
        held_meas <= a_value_meas;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_b <= '0;
    else if (lead_evt) cap_b <= tbase;
    else if (per_evt)  cap_b <= pend ? held : cap_a;
  end

endmodule

// File: rtl/icap_flag.sv
module icap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int unsigned TB_W        = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] tbase,
  input  logic            pin_in,
  input  logic            cfg_period,
  input  logic            cfg_pol,
  input  logic            rd_en,
  input  logic            rd_sel,
  output logic [TB_W-1:0] rd_data,
  input  logic            flag_wr,
  input  logic            flag_wdata,
  output logic            flag
);

  logic            rise_evt;
  logic            fall_evt;
  logic            a_blocked;
  logic            clr_req;
  logic [TB_W-1:0] cap_a;
  logic [TB_W-1:0] cap_b;
  logic            pend;
  logic            lead_evt;
  logic            a_evt;
  logic            a_commit;
  logic            meas_commit;

  assign a_blocked = rd_en && (icap_sel_e'(rd_sel) == SEL_A);
  assign clr_req   = flag_wr && flag_wdata;
  assign rd_data   = (icap_sel_e'(rd_sel) == SEL_B) ? cap_b : cap_a;

  icap_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  icap_capture #(.TB_W(TB_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .tbase       (tbase),
    .cfg_period  (cfg_period),
    .cfg_pol     (cfg_pol),
    .rise_evt    (rise_evt),
    .fall_evt    (fall_evt),
    .a_blocked   (a_blocked),
    .cap_a       (cap_a),
    .cap_b       (cap_b),
    .pend        (pend),
    .lead_evt    (lead_evt),
    .a_evt       (a_evt),
    .a_commit    (a_commit),
    .meas_commit (meas_commit)
  );

  icap_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (meas_commit),
    .clr_req (clr_req),
    .flag_q  (flag)
  );

endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk #(
  parameter int unsigned TB_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en,
  input logic            rd_sel,
  input logic            flag_wr,
  input logic            flag_wdata,
  input logic            flag,
  input logic            cfg_period,
  input logic            rise_evt,
  input logic            fall_evt,
  input logic            lead_evt,
  input logic            pend,
  input logic            meas_commit,
  input logic [TB_W-1:0] cap_a,
  input logic [TB_W-1:0] cap_b
);

  // R2: the edge detector reports at most one direction per cycle
  p_one_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_evt, fall_evt}));

  // R7: a completed measurement raises the flag
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    meas_commit |=> flag);

  // R8: a clear with no completion in the same cycle drops the flag
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && flag_wdata && !meas_commit) |=> !flag);

  // R8: writing zero has no effect
  p_flag_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(flag_wr && flag_wdata)) |=> flag);

  // R10: a read of A freezes A for that cycle
  p_a_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel) |=> $stable(cap_a));

  // R10: a held capture lands on the first cycle that does not read A
  p_pend_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(rd_en && !rd_sel)) |=> !pend);

  // R3: in pulse-width mode only a leading edge moves B
  p_b_lead_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_period && !lead_evt) |=> $stable(cap_b));

endmodule

bind icap_channel icap_channel_chk #(.TB_W(TB_W)) u_icap_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_en       (rd_en),
  .rd_sel      (rd_sel),
  .flag_wr     (flag_wr),
  .flag_wdata  (flag_wdata),
  .flag        (flag),
  .cfg_period  (cfg_period),
  .rise_evt    (rise_evt),
  .fall_evt    (fall_evt),
  .lead_evt    (lead_evt),
  .pend        (pend),
  .meas_commit (meas_commit),
  .cap_a       (cap_a),
  .cap_b       (cap_b)
);

// File: tb/test_icap_channel.sv
module test_icap_channel;

  localparam int CLK_PERIOD = 10;
  localparam int TBW        = 24;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [TBW-1:0] cnt = '0;
  logic [TBW-1:0] off = '0;
  logic [TBW-1:0] tbase;
  logic           pin_in = 1'b0;
  logic           cfg_period = 1'b0;
  logic           cfg_pol = 1'b0;
  logic           rd_en = 1'b0;
  logic           rd_sel = 1'b0;
  logic [TBW-1:0] rd_data;
  logic           flag_wr = 1'b0;
  logic           flag_wdata = 1'b0;
  logic           flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cnt <= cnt + 1'b1;
  assign tbase = cnt + off;

  icap_channel i_icap_channel (
    .clk        (clk),
    .rst_n      (rst_n),
    .tbase      (tbase),
    .pin_in     (pin_in),
    .cfg_period (cfg_period),
    .cfg_pol    (cfg_pol),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .flag       (flag)
  );

  task automatic check(input string tag, input logic [TBW-1:0] act, input logic [TBW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [TBW-1:0] span(input logic [TBW-1:0] late, input logic [TBW-1:0] early);
    int signed d;
    d = int'(late) - int'(early);
    if (d < 0) d += (1 << TBW);
    return d[TBW-1:0];
  endfunction

  task automatic read_reg(input logic sel, output logic [TBW-1:0] v);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  // Drive a pin level, stamp the time base in force at the third rising edge,
  // optionally read A or clear the flag in that cycle; end one half cycle after.
  task automatic edge_to(input logic v, input logic rd_conf, input logic clr_same,
                         output logic [TBW-1:0] stamp);
    @(negedge clk); pin_in = v;
    @(posedge clk); @(posedge clk);
    @(negedge clk); #1 stamp = tbase;
    if (rd_conf) begin rd_en = 1'b1; rd_sel = 1'b0; end
    if (clr_same) begin flag_wr = 1'b1; flag_wdata = 1'b1; end
    @(posedge clk);
    @(negedge clk); #1;
    flag_wr = 1'b0;
  endtask

  task automatic clear_flag(input logic wd);
    @(negedge clk); flag_wr = 1'b1; flag_wdata = wd;
    @(negedge clk); flag_wr = 1'b0; #1;
  endtask

  task automatic set_cfg(input logic per, input logic pol);
    @(negedge clk); cfg_period = per; cfg_pol = pol;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [TBW-1:0] v;
    read_reg(1'b0, v); check("R1 A after reset", v, '0);
    read_reg(1'b1, v); check("R1 B after reset", v, '0);
    check("R1 flag after reset", {23'd0, flag}, 24'd1 - 24'd1);
  endtask

  task automatic t_neg_pulse;
    logic [TBW-1:0] s, tl, tt, v;
    edge_to(1'b1, 1'b0, 1'b0, s);
    read_reg(1'b0, v); check("R4 orphan trailing edge leaves A", v, '0);
    check("R4 orphan trailing edge no flag", {23'd0, flag}, '0);
    edge_to(1'b0, 1'b0, 1'b0, tl);
    read_reg(1'b1, v); check("R3 R2 negative leading edge into B", v, tl);
    check("R7 no flag on leading edge", {23'd0, flag}, '0);
    edge_to(1'b1, 1'b0, 1'b0, tt);
    read_reg(1'b0, v); check("R3 R2 negative trailing edge into A", v, tt);
    check("R7 flag after trailing edge", {23'd0, flag}, 24'd1);
    read_reg(1'b1, v); check("R9 select B returns B", v, tl);
  endtask

  task automatic t_flag_clear;
    clear_flag(1'b0); check("R8 write zero keeps flag", {23'd0, flag}, 24'd1);
    clear_flag(1'b1); check("R8 write one clears flag", {23'd0, flag}, '0);
    repeat (3) @(negedge clk);
    check("R7 flag stays low without event", {23'd0, flag}, '0);
  endtask

  task automatic t_pos_pulse_conflict;
    logic [TBW-1:0] tl, tt, old_a, v;
    edge_to(1'b0, 1'b0, 1'b0, tl);
    set_cfg(1'b0, 1'b1);
    read_reg(1'b0, old_a);
    edge_to(1'b1, 1'b0, 1'b0, tl);
    read_reg(1'b1, v); check("R3 positive leading edge into B", v, tl);
    edge_to(1'b0, 1'b1, 1'b0, tt);
    check("R10 read during capture returns old A", rd_data, old_a);
    check("R10 flag waits for deferred capture", {23'd0, flag}, '0);
    @(negedge clk); #1;
    check("R10 A still held while read continues", rd_data, old_a);
    rd_en = 1'b0;
    @(negedge clk); #1;
    read_reg(1'b0, v); check("R10 deferred A holds edge stamp", v, tt);
    check("R10 flag rises at deferred store", {23'd0, flag}, 24'd1);
    clear_flag(1'b1);
    edge_to(1'b1, 1'b0, 1'b0, tl);
    edge_to(1'b0, 1'b0, 1'b1, tt);
    check("R8 completion beats same-cycle clear", {23'd0, flag}, 24'd1);
    read_reg(1'b0, v); check("R3 positive trailing edge into A", v, tt);
    clear_flag(1'b1);
  endtask

  task automatic t_wrap;
    logic [TBW-1:0] tl, tt, a, b;
    @(negedge clk); #1 off = 24'hFFFFF8 - cnt;
    edge_to(1'b1, 1'b0, 1'b0, tl);
    repeat (6) @(negedge clk);
    edge_to(1'b0, 1'b0, 1'b0, tt);
    read_reg(1'b0, a); read_reg(1'b1, b);
    check("R11 raw B before rollover", b, tl);
    check("R11 raw A after rollover", a, tt);
    check("R11 width across rollover", span(a, b), 24'd10);
    clear_flag(1'b1);
  endtask

  task automatic t_period;
    logic [TBW-1:0] t1, t2, t3, s, v;
    set_cfg(1'b1, 1'b1);
    edge_to(1'b1, 1'b0, 1'b0, t1);
    read_reg(1'b0, v); check("R5 first rising edge into A", v, t1);
    check("R6 first period capture no flag", {23'd0, flag}, '0);
    edge_to(1'b0, 1'b0, 1'b0, s);
    read_reg(1'b0, v); check("R5 falling edge ignored", v, t1);
    edge_to(1'b1, 1'b0, 1'b0, t2);
    read_reg(1'b0, v); check("R5 second rising edge into A", v, t2);
    read_reg(1'b1, v); check("R5 earlier edge moved to B", v, t1);
    check("R5 span of one period", span(t2, t1), 24'd8);
    check("R7 flag after period", {23'd0, flag}, 24'd1);
    clear_flag(1'b1);
    edge_to(1'b0, 1'b0, 1'b0, s);
    edge_to(1'b1, 1'b1, 1'b0, t3);
    check("R12 A held during read", rd_data, t2);
    rd_sel = 1'b1; #1;
    check("R12 B moved at edge despite hold", rd_data, t2);
    rd_sel = 1'b0; rd_en = 1'b0;
    @(negedge clk); #1;
    read_reg(1'b0, v); check("R12 A stored after release", v, t3);
    check("R12 flag after deferred period", {23'd0, flag}, 24'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_neg_pulse();
    t_flag_clear();
    t_pos_pulse_conflict();
    t_wrap();
    t_period();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule